// File: doc/BRIEF.md
# Compound Prefix Adder (Sum and Sum-Plus-One)

This block adds two unsigned operands and returns two results in the same cycle: the plain sum A+B and the incremented sum A+B+1. Each result has its own carry-out. A downstream stage, such as a rounding step, can then pick one of the two results late in the cycle. It does not have to wait for a second carry chain. The block is purely combinational and has no clock or state.

The operands first go through per-bit cells. Each cell forms a generate bit, an exclusive-or propagate bit and a not-kill bit. A log-depth prefix tree then combines the generate and not-kill bits in the Ladner-Fischer pattern. In an ordinary prefix adder, the cells whose span reaches bit 0 compute only the group generate. Here those cells are full cells that also return the group not-kill term. So every bit position receives both the "carry with carry-in 0" and the "carry with carry-in 1" from one tree. Two sum rows exclusive-or the propagate bits with these carries to form the two results.

Top module: `flag_prefix_adder`

## Requirements
- R1: `sum_o` and `sum_co_o` together equal A+B as a 17-bit value, with `sum_co_o` as bit 16, for every operand pair.
- R2: `sum1_o` and `sum1_co_o` together equal A+B+1 as a 17-bit value, with `sum1_co_o` as bit 16, for every operand pair.
- R3: When every bit position propagates (A XOR B = 16'hFFFF), the plain result is 16'hFFFF with carry-out 0. The incremented result is 16'h0000 with carry-out 1.
- R4: With both operands 16'hFFFF, the plain result is 16'hFFFE with carry-out 1. The incremented result is 16'hFFFF with carry-out 1.
- R5: With both operands zero, the plain result is 16'h0000 and the incremented result is 16'h0001. Both carry-outs are 0.
- R6: `sum1_o` XOR `sum_o` is never zero. It is always a run of ones starting at bit 0 (of the form 2^k-1, k from 1 to 16).
- R7: The outputs follow an operand change with no clock edge, as combinational logic does.
- R8: A carry-in of one reaches every bit position through a propagate run from bit 0. For A = 2^(k+1)-1 and B = 0, the incremented result is 2^(k+1), with carry-out set only for k = 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| sum_o | output | 16 | Low 16 bits of A+B |
| sum_co_o | output | 1 | Carry-out of A+B |
| sum1_o | output | 16 | Low 16 bits of A+B+1 |
| sum1_co_o | output | 1 | Carry-out of A+B+1 |

## Verification
Both results come from the same prefix tree in every evaluation. The interesting coincidence is an operand pair where one result overflows and the other does not. This happens when the propagate string covers all sixteen bits: the plain sum stays at 16'hFFFF while the incremented sum wraps to zero with a carry-out. The bench provokes this case directly, through exhaustive low-nibble sweeps with fixed upper patterns, and through random pairs. Every pair is judged against a 17-bit reference addition computed in the bench for both results at once. The XOR of the two results is also checked to be a low run of ones.

// File: rtl/flag_adder_pkg.sv
package flag_adder_pkg;

  // Source column for the Ladner-Fischer cell at column i, level lvl.
  function automatic int lf_src(input int i, input int lvl);
    return ((i >> (lvl + 1)) << (lvl + 1)) + (1 << lvl) - 1;
  endfunction

  // A cell is active at level lvl when bit lvl of its column index is set.
  function automatic bit lf_active(input int i, input int lvl);
    return ((i >> lvl) & 1) == 1;
  endfunction

  // The cell's span reaches column 0 (a grey cell in a plain prefix adder).
  function automatic bit lf_rooted(input int i, input int lvl);
    return (i >> (lvl + 1)) == 0;
  endfunction

  // True when v is a nonzero run of ones starting at bit 0.
  function automatic bit low_run(input logic [31:0] v);
    return (v != 32'd0) && (((v + 32'd1) & v) == 32'd0);
  endfunction

endpackage

// File: rtl/fpa_bit_cells.sv
module fpa_bit_cells #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] xprop_o,
  output logic [WIDTH-1:0] nkill_o
);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign gen_o[i]   = a_i[i] & b_i[i];
      assign xprop_o[i] = a_i[i] ^ b_i[i];
      assign nkill_o[i] = a_i[i] | b_i[i];
    end
  endgenerate

  always_comb begin
    if (!$isunknown({gen_o, xprop_o, nkill_o})) begin
      AST_GEN_NOT_KILL: assert ((gen_o & ~nkill_o) == '0) // R1
        else $error("generate without not-kill");
      AST_GEN_XPROP_EXCL: assert ((gen_o & xprop_o) == '0) // R1
        else $error("generate and propagate both set");
    end
  end

endmodule

// File: rtl/fpa_prefix_cell.sv
module fpa_prefix_cell #(
  parameter bit FULL = 1'b1
) (
  input  logic g_hi_i,
  input  logic t_hi_i,
  input  logic g_lo_i,
  input  logic t_lo_i,
  output logic g_o,
  output logic t_o
);

  assign g_o = g_hi_i | (t_hi_i & g_lo_i);

  generate
    if (FULL) begin : g_full
      assign t_o = t_hi_i & t_lo_i;
    end else begin : g_gen_only
      assign t_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/fpa_lf_tree.sv
module fpa_lf_tree
  import flag_adder_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit FLAGGED = 1'b1
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] nkill_i,
  output logic [WIDTH-1:0] grp_gen_o,
  output logic [WIDTH-1:0] grp_nk_o
);

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] g_lvl [0:LEVELS];
  logic [WIDTH-1:0] t_lvl [0:LEVELS];

  assign g_lvl[0] = gen_i;
  assign t_lvl[0] = nkill_i;

  genvar l, i;
  generate
    for (l = 0; l < LEVELS; l++) begin : g_level
      for (i = 0; i < WIDTH; i++) begin : g_col
        if (lf_active(i, l)) begin : g_cell
          localparam int SRC  = lf_src(i, l);
          localparam bit FULL = FLAGGED || !lf_rooted(i, l);
          fpa_prefix_cell #(.FULL(FULL)) u_cell (
            .g_hi_i (g_lvl[l][i]),
            .t_hi_i (t_lvl[l][i]),
            .g_lo_i (g_lvl[l][SRC]),
            .t_lo_i (t_lvl[l][SRC]),
            .g_o    (g_lvl[l+1][i]),
            .t_o    (t_lvl[l+1][i])
          );
        end else begin : g_wire
          assign g_lvl[l+1][i] = g_lvl[l][i];
          assign t_lvl[l+1][i] = t_lvl[l][i];
        end
      end
    end
  endgenerate

  assign grp_gen_o = g_lvl[LEVELS];
  assign grp_nk_o  = t_lvl[LEVELS];

  always_comb begin
    if (!$isunknown({gen_i, nkill_i, grp_gen_o, grp_nk_o})) begin
      AST_ROOT_COLUMN: assert (grp_gen_o[0] == gen_i[0] && grp_nk_o[0] == nkill_i[0]) // R1
        else $error("column 0 prefix differs from its bit");
      AST_ALL_NK_SPAN: assert ((&nkill_i) == grp_nk_o[WIDTH-1] || !FLAGGED) // R2
        else $error("full-span not-kill wrong");
    end
  end

endmodule

// File: rtl/fpa_sum_rows.sv
module fpa_sum_rows #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] xprop_i,
  input  logic [WIDTH-1:0] grp_gen_i,
  input  logic [WIDTH-1:0] grp_nk_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             sum_co_o,
  output logic [WIDTH-1:0] sum1_o,
  output logic             sum1_co_o
);

  logic [WIDTH-1:0] cin0;
  logic [WIDTH-1:0] cin1;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_row
      if (i == 0) begin : g_lsb
        assign cin0[i] = 1'b0;
        assign cin1[i] = 1'b1;
      end else begin : g_upper
        assign cin0[i] = grp_gen_i[i-1];
        assign cin1[i] = grp_gen_i[i-1] | grp_nk_i[i-1];
      end
    end
  endgenerate

  assign sum_o     = xprop_i ^ cin0;
  assign sum1_o    = xprop_i ^ cin1;
  assign sum_co_o  = grp_gen_i[WIDTH-1];
  assign sum1_co_o = grp_gen_i[WIDTH-1] | grp_nk_i[WIDTH-1];

  always_comb begin
    if (!$isunknown({cin0, cin1})) begin
      AST_CARRY_ORDER: assert ((cin0 & ~cin1) == '0) // R2
        else $error("carry with cin 0 set where carry with cin 1 is clear");
    end
  end

endmodule

// File: rtl/flag_prefix_adder.sv
module flag_prefix_adder
  import flag_adder_pkg::*;
(
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  output logic [15:0] sum_o,
  output logic        sum_co_o,
  output logic [15:0] sum1_o,
  output logic        sum1_co_o
);

  localparam int WIDTH = 16;

  logic [WIDTH-1:0] gen_w;
  logic [WIDTH-1:0] xprop_w;
  logic [WIDTH-1:0] nkill_w;
  logic [WIDTH-1:0] grp_gen_w;
  logic [WIDTH-1:0] grp_nk_w;

  fpa_bit_cells #(.WIDTH(WIDTH)) u_bits (
    .a_i     (a_i),
    .b_i     (b_i),
    .gen_o   (gen_w),
    .xprop_o (xprop_w),
    .nkill_o (nkill_w)
  );

  fpa_lf_tree #(.WIDTH(WIDTH), .FLAGGED(1'b1)) u_tree (
    .gen_i     (gen_w),
    .nkill_i   (nkill_w),
    .grp_gen_o (grp_gen_w),
    .grp_nk_o  (grp_nk_w)
  );

  fpa_sum_rows #(.WIDTH(WIDTH)) u_rows (
    .xprop_i   (xprop_w),
    .grp_gen_i (grp_gen_w),
    .grp_nk_i  (grp_nk_w),
    .sum_o     (sum_o),
    .sum_co_o  (sum_co_o),
    .sum1_o    (sum1_o),
    .sum1_co_o (sum1_co_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, sum_o, sum_co_o, sum1_o, sum1_co_o})) begin
      AST_PLAIN_SUM: assert ({sum_co_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i})) // R1
        else $error("plain result wrong");
      AST_INC_STEP: assert ({sum1_co_o, sum1_o} == ({sum_co_o, sum_o} + 17'd1)) // R2
        else $error("incremented result not plain plus one");
      AST_LOW_RUN: assert (low_run({15'd0, sum1_co_o ^ sum_co_o, sum1_o ^ sum_o})) // R6
        else $error("increment flip mask is not a low run");
    end
  end

endmodule

// File: tb/tb_flag_prefix_adder.sv
`timescale 1ns/1ps
module tb_flag_prefix_adder;

  logic clk;
  logic [15:0] a;
  logic [15:0] b;
  logic [15:0] s0;
  logic [15:0] s1;
  logic        c0;
  logic        c1;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  flag_prefix_adder dut (
    .a_i       (a),
    .b_i       (b),
    .sum_o     (s0),
    .sum_co_o  (c0),
    .sum1_o    (s1),
    .sum1_co_o (c1)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #500000;
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic cmp(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
    end
  endtask

  // Drives a pair and checks both results against a 17-bit reference (R1, R2, R6).
  task automatic apply(input logic [15:0] av, input logic [15:0] bv);
    logic [16:0] e0;
    logic [16:0] e1;
    logic [16:0] diff;
    @(negedge clk);
    a = av;
    b = bv;
    #1;
    e0 = {1'b0, av} + {1'b0, bv};
    e1 = e0 + 17'd1;
    cmp("R1", {c0, s0}, e0);
    cmp("R2", {c1, s1}, e1);
    diff = {c0, s0} ^ {c1, s1};
    cmp("R6", {16'd0, (diff != 0) && (((diff + 17'd1) & diff) == 0)}, 17'd1);
  endtask

  task automatic t_zero;
    apply(16'h0000, 16'h0000);
    cmp("R5", {c0, s0}, 17'h00000);
    cmp("R5", {c1, s1}, 17'h00001);
  endtask

  task automatic t_full_propagate;
    apply(16'hA5C3, 16'h5A3C);
    cmp("R3", {c0, s0}, 17'h0FFFF);
    cmp("R3", {c1, s1}, 17'h10000);
    apply(16'hFFFF, 16'h0000);
    cmp("R3", {c1, s1}, 17'h10000);
  endtask

  task automatic t_all_ones;
    apply(16'hFFFF, 16'hFFFF);
    cmp("R4", {c0, s0}, 17'h1FFFE);
    cmp("R4", {c1, s1}, 17'h1FFFF);
  endtask

  task automatic t_comb_response;
    @(negedge clk);
    a = 16'h1234;
    b = 16'h0001;
    #0.5;
    cmp("R7", {c0, s0}, 17'h01235);
    a = 16'h8000;
    b = 16'h8000;
    #0.5;
    cmp("R7", {c0, s0}, 17'h10000);
    cmp("R7", {c1, s1}, 17'h10001);
  endtask

  task automatic t_carry_reach;
    for (int k = 0; k < 16; k++) begin
      logic [16:0] run;
      run = (17'd1 << (k + 1)) - 17'd1;
      apply(run[15:0], 16'h0000);
      cmp("R8", {c1, s1}, 17'd1 << (k + 1));
    end
  endtask

  task automatic t_low_nibbles;
    for (int hi = 0; hi < 3; hi++) begin
      logic [15:0] up;
      up = (hi == 0) ? 16'h0000 : (hi == 1) ? 16'hFFF0 : 16'h7FF0;
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          apply(up | 16'(x), (hi == 2 ? 16'h8000 : up ^ 16'hFFF0) | 16'(y));
        end
      end
    end
  endtask

  task automatic t_random;
    int unsigned seed = 32'h1F2E3D4C;
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom(seed + n);
      apply(r[15:0], r[31:16]);
    end
  endtask

  initial begin
    a = '0;
    b = '0;
    repeat (2) @(posedge clk);
    t_zero();
    t_full_propagate();
    t_all_ones();
    t_comb_response();
    t_carry_reach();
    t_low_nibbles();
    t_random();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule